// File: doc/BRIEF.md
# Task Context Bank with Round-Robin Switching

This block keeps the per-task execution context of a small non-pipelined processor: one program counter and one zero flag and one carry flag for each of up to four tasks. Task 0 is the base context and can always run. Tasks 1 to 3 run only while their enable bit is set. Every other register is shared between tasks and is not part of this block. The block also decides which context drives the fetch stage, so the program counter, the flags and the task number it presents all belong to the task that now owns the processor.

The processor pulses `instr_done` once per finished instruction. With this pulse it supplies the next program counter, flag writes with their write strobes, and an optional task-switch request. A plain switch saves the current program counter plus one as the resume point of the task that yields. An immediate switch saves a supplied target address instead. A switch then hands control to the next eligible task in round-robin order. In normal mode the same task keeps running until it switches. In threaded mode the block moves to the next eligible task on every finished instruction, so two enabled tasks get equal turns.

Top module: `task_ctx_bank`

## Requirements
- R1: While reset is asserted and after it is released, every task program counter is 0, every zero and carry flag is 0, and task 0 is the active task.
- R2: `pc_out`, `z_out` and `c_out` always show the stored context of the task given by `task_id`. They are combinational from the stored state.
- R3: In normal mode (`thread_mode`=0), an `instr_done` without `sw_req` writes `next_pc` into the active task's program counter and leaves `task_id` unchanged.
- R4: While `instr_done` is 0, the active task and all stored program counters and flags hold their values, whatever the other inputs are.
- R5: An `instr_done` with `sw_req`=1 and `sw_imm`=0 stores the active task's program counter plus one (modulo 2^PCW) as that task's resume address and ignores `next_pc`.
- R6: An `instr_done` with `sw_req`=1 and `sw_imm`=1 stores `sw_target` as the yielding task's resume address.
- R7: In threaded mode every `instr_done` moves the active task to the next eligible task, so two eligible tasks alternate on every finished instruction. If `sw_req` is 0, `next_pc` is written as in R3.
- R8: The next task is found by searching upward from the active task number and wrapping from 3 to 0. Task 0 is always eligible, `task_en[0]` is ignored, and a task k>0 is eligible only when `task_en[k]`=1.
- R9: A flag write (`z_wr` or `c_wr` together with `instr_done`) changes only the flag of the task that was active for that instruction. Without its strobe a flag keeps its value.
- R10: If no other task is eligible, a switch or a threaded-mode step leaves the same task active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_mode | input | 1 | 1 selects threaded mode: switch task on every finished instruction |
| task_en | input | NTASK | Eligibility of tasks 1..NTASK-1; bit 0 is ignored |
| instr_done | input | 1 | Pulse for one finished instruction of the active task |
| sw_req | input | 1 | Switch-task request for this instruction |
| sw_imm | input | 1 | 1 saves `sw_target` as the resume address; 0 saves PC+1 |
| sw_target | input | PCW | Immediate resume address |
| next_pc | input | PCW | Next program counter from the datapath |
| z_wr | input | 1 | Write strobe for the zero flag |
| z_in | input | 1 | New zero flag |
| c_wr | input | 1 | Write strobe for the carry flag |
| c_in | input | 1 | New carry flag |
| task_id | output | IDW | Active task number |
| pc_out | output | PCW | Program counter of the active task |
| z_out | output | 1 | Zero flag of the active task |
| c_out | output | 1 | Carry flag of the active task |

## Verification
Every result of an `instr_done` pulse shows one clock edge later. The saved program counter, the flag writes and the new active task all update on that edge, and the outputs then follow the new task through combinational selection. The bench drives each stimulus on a falling edge and compares all four outputs against its own model on the next falling edge. Each stimulus is therefore checked exactly one cycle after it was applied, and stores into tasks that are not active are checked when the rotation later makes those tasks active.

// File: rtl/task_ctx_bank.sv
module task_ctx_bank #(
  parameter int NTASK = 4,
  parameter int PCW   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thread_mode,
  input  logic [NTASK-1:0] task_en,
  input  logic             instr_done,
  input  logic             sw_req,
  input  logic             sw_imm,
  input  logic [PCW-1:0]   sw_target,
  input  logic [PCW-1:0]   next_pc,
  input  logic             z_wr,
  input  logic             z_in,
  input  logic             c_wr,
  input  logic             c_in,
  output logic [((NTASK>1)?$clog2(NTASK):1)-1:0] task_id,
  output logic [PCW-1:0]   pc_out,
  output logic             z_out,
  output logic             c_out
);
  localparam int IDW = (NTASK > 1) ? $clog2(NTASK) : 1;

  logic [PCW-1:0]   pc_q [NTASK];
  logic [NTASK-1:0] z_q, c_q;
  logic [IDW-1:0]   act, nxt;
  logic [NTASK-1:0] elig, act_oh;

  assign elig    = task_en | NTASK'(1);
  assign act_oh  = NTASK'(1) << act;
  assign task_id = act;
  assign pc_out  = pc_q[act];
  assign z_out   = z_q[act];
  assign c_out   = c_q[act];

  always_comb begin
    logic hit;
    logic [IDW-1:0] cand;
    nxt = act;
    hit = 1'b0;
    for (int k = 1; k < NTASK; k++) begin
      cand = IDW'((int'(act) + k) % NTASK);
      if (!hit && elig[cand]) begin
        nxt = cand;
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTASK; i++) pc_q[i] <= '0;
      z_q <= '0;
      c_q <= '0;
      act <= '0;
    end else if (instr_done) begin
      if (sw_req) pc_q[act] <= sw_imm ? sw_target : pc_q[act] + PCW'(1);
      else        pc_q[act] <= next_pc;
      if (z_wr) z_q[act] <= z_in;
      if (c_wr) c_q[act] <= c_in;
      if (sw_req || thread_mode) act <= nxt;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(act) && $stable(z_q) && $stable(c_q)); // R4

  AST_NORMAL_KEEPS_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done && !thread_mode && !sw_req |=> task_id == $past(task_id)); // R3

  AST_PLAIN_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done && sw_req && !sw_imm |=> pc_q[$past(act)] == $past(pc_out) + PCW'(1)); // R5

  AST_IMM_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done && sw_req && sw_imm |=> pc_q[$past(act)] == $past(sw_target)); // R6

  AST_LEAVES_WHEN_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done && (sw_req || thread_mode) && ((elig & ~act_oh) != '0)
    |=> task_id != $past(task_id)); // R7

  AST_FLAG_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (((z_q ^ $past(z_q)) | (c_q ^ $past(c_q))) & ~$past(act_oh)) == '0); // R9

  AST_LONE_TASK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done && ((elig & ~act_oh) == '0) |=> $stable(act)); // R10
endmodule

// File: tb/sim_task_ctx_bank.sv
module sim_task_ctx_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int PW = 17;

  logic clk = 0, rst_n = 0;
  logic thread_mode = 0, instr_done = 0, sw_req = 0, sw_imm = 0;
  logic [NT-1:0] task_en = '0;
  logic [PW-1:0] sw_target = '0, next_pc = '0;
  logic z_wr = 0, z_in = 0, c_wr = 0, c_in = 0;
  logic [1:0] task_id;
  logic [PW-1:0] pc_out;
  logic z_out, c_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  logic [PW-1:0] m_pc [NT];
  logic [NT-1:0] m_z, m_c;
  int m_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_ctx_bank #(.NTASK(NT), .PCW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .thread_mode(thread_mode), .task_en(task_en),
    .instr_done(instr_done), .sw_req(sw_req), .sw_imm(sw_imm), .sw_target(sw_target),
    .next_pc(next_pc), .z_wr(z_wr), .z_in(z_in), .c_wr(c_wr), .c_in(c_in),
    .task_id(task_id), .pc_out(pc_out), .z_out(z_out), .c_out(c_out));

  function automatic int next_task(int a, logic [NT-1:0] en);
    for (int k = 1; k < NT; k++) begin
      int idx = (a + k) % NT;
      if (idx == 0 || en[idx]) return idx;
    end
    return a;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "task_id", int'(task_id), m_act);
    chk({tag, " R2"}, "pc_out", int'(pc_out), int'(m_pc[m_act]));
    chk("R9", "z_out", int'(z_out), int'(m_z[m_act]));
    chk("R9", "c_out", int'(c_out), int'(m_c[m_act]));
  endtask

  task automatic step(logic tm, logic [NT-1:0] en, logic dn, logic sw, logic imm,
                      logic [PW-1:0] tgt, logic [PW-1:0] npc,
                      logic zw, logic zi, logic cw, logic ci, string tag);
    thread_mode = tm; task_en = en; instr_done = dn; sw_req = sw; sw_imm = imm;
    sw_target = tgt; next_pc = npc; z_wr = zw; z_in = zi; c_wr = cw; c_in = ci;
    if (dn) begin
      if (sw) m_pc[m_act] = imm ? tgt : m_pc[m_act] + PW'(1);
      else    m_pc[m_act] = npc;
      if (zw) m_z[m_act] = zi;
      if (cw) m_c[m_act] = ci;
      if (sw || tm) m_act = next_task(m_act, en);
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NT; i++) m_pc[i] = '0;
    m_z = '0; m_c = '0; m_act = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R4: no completion pulse, other inputs busy
    step(1, 4'b1110, 0, 1, 1, 17'h1ABCD, 17'h00777, 1, 1, 1, 1, "R4");
    // R3: normal completion
    step(0, 4'b1110, 1, 0, 0, 17'h0, 17'd5, 0, 0, 0, 0, "R3");
    // R5 / R1: plain switch to task 1, whose pc is still zero
    step(0, 4'b1110, 1, 1, 0, 17'h0, 17'h1FFFF, 0, 0, 0, 0, "R5");
    step(0, 4'b1110, 1, 1, 0, 17'h0, 17'h0, 0, 0, 0, 0, "R5");
    // R8: task 3 disabled, task 0 is eligible even with en[0]=0
    step(0, 4'b0000, 1, 1, 0, 17'h0, 17'h0, 0, 0, 0, 0, "R8");
    // R6: immediate resume address
    step(0, 4'b0010, 1, 1, 1, 17'h01234, 17'h0, 0, 0, 0, 0, "R6");
    step(0, 4'b0010, 1, 1, 0, 17'h0, 17'h0, 0, 0, 0, 0, "R8");
    // R9: flag writes on task 0 do not reach task 1
    step(1, 4'b0010, 1, 0, 0, 17'h0, 17'd40, 1, 1, 1, 1, "R9");
    step(1, 4'b0010, 1, 0, 0, 17'h0, 17'd60, 0, 1, 0, 1, "R9");
    // R7: alternate between two tasks
    for (int i = 0; i < 6; i++)
      step(1, 4'b0010, 1, 0, 0, 17'h0, PW'(100 + i), 0, 0, 0, 0, "R7");
    // R5: PC+1 wraps at the top of the address range
    step(0, 4'b0000, 1, 1, 1, 17'h1FFFF, 17'h0, 0, 0, 0, 0, "R6");
    step(0, 4'b0000, 1, 1, 0, 17'h0, 17'h0, 0, 0, 0, 0, "R5");
    // R10: task 0 alone
    step(0, 4'b0000, 1, 1, 0, 17'h0, 17'h0, 0, 0, 0, 0, "R10");
    step(1, 4'b0001, 1, 0, 0, 17'h0, 17'd9, 0, 0, 0, 0, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic tm, dn, sw, imm;
      logic [NT-1:0] en;
      string tag;
      tm  = ($urandom % 3) == 0;
      dn  = ($urandom % 4) != 0;
      sw  = ($urandom % 4) == 0;
      imm = $urandom % 2;
      en  = NT'($urandom);
      if (!dn) tag = "R4";
      else if (sw && imm) tag = "R6";
      else if (sw) tag = "R5";
      else if (tm) tag = "R7";
      else tag = "R3";
      step(tm, en, dn, sw, imm, PW'($urandom), PW'($urandom),
           $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, tag);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule